// File: doc/BRIEF.md
# Byte-Maskable Pseudo-Static RAM Control Front End

This block models the control side of a 16-bit pseudo-static RAM with byte masking. Each clock it samples a set of active-low pins: chip select, output enable, write enable, an upper and a lower byte strobe, and a low-power request. It decodes them into one of five operating modes. Writes land in a small internal array, one byte lane or both. Reads present data and a separate output-enable for each lane once a latency counted in clock cycles has passed.

A read that stays within one 16-word page and changes only the low four address bits completes with a shorter latency. A deep power-down mode stops all lane activity and discards the stored contents. A parameter picks the behaviour of the low-power pin. In the direct variant it always forces power-down. In the armed variant it has effect only while an arm input is high. After power-down, or after reset, every byte is unknown. A read of such a byte returns a fixed poison pattern and raises a status flag.

Top module: `psram_front`

## Requirements
- R1: After reset the mode output is 0 (deselected), both lane enables and the valid flag are low, and every byte of the array is unwritten.
- R2: With chip select high and the low-power pin high, the mode is 0 (deselected) and neither lane is driven, whatever the other pins are.
- R3: With DIRECT_PD=1, the low-power pin low puts the block in mode 1 (power-down) regardless of chip select. Neither lane is driven, and write requests are ignored.
- R4: With DIRECT_PD=0, the low-power pin low has no effect while the arm input is low. While arm is high it selects mode 1 exactly as in R3.
- R5: Chip select low with both output enable and write enable high, or with both byte strobes high, gives mode 2 (output disabled). Neither lane is driven and nothing is written.
- R6: Chip select low, write enable high and output enable low give mode 3 (read). Lower strobe low enables lane bits 7:0 and upper strobe low enables bits 15:8. A lane that is not enabled reads as zero on the data output.
- R7: Chip select low with write enable low gives mode 4 (write) even when output enable is low. At that clock edge only the bytes whose strobe is low are stored, and no lane is driven.
- R8: A read that starts a new access, either by entering read mode or by changing address outside the current page, raises the valid flag and the lane enables after exactly ACC_LAT clock edges, counted from the first edge that samples it.
- R9: A read whose address changes while the previous cycle was a read of the same page (equal address bits above bit 3) completes after PAGE_LAT edges.
- R10: Entering power-down marks every byte unwritten. A read of an unwritten byte returns the matching byte of POISON (default 16'hDEAD) and raises the poison flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| ubN | input | 1 | Upper byte strobe (bits 15:8), active low |
| lbN | input | 1 | Lower byte strobe (bits 7:0), active low |
| zzN | input | 1 | Low-power request, active low |
| pdArm | input | 1 | Power-down arm bit for the armed variant |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data; lanes that are not enabled read zero |
| laneOeLo | output | 1 | Drive enable for bits 7:0 |
| laneOeHi | output | 1 | Drive enable for bits 15:8 |
| rdValid | output | 1 | Read data is valid |
| rdPoison | output | 1 | An enabled lane holds an unwritten byte |
| modeOut | output | 3 | Registered mode: 0 deselect, 1 power-down, 2 output off, 3 read, 4 write |

## Verification
The bench builds two copies with ADDR_W=6, ACC_LAT=3 and PAGE_LAT=1. One copy uses DIRECT_PD=1 and the other DIRECT_PD=0, and both receive the same pins. A 64-word array is small enough to write and read back at every address with arithmetic patterns. The short latencies put both the full-latency path and the page-hit path within a few cycles, so all 16 words of one page are swept in one burst. Because the two variants see identical stimulus, the same low-power request shows one copy losing its data while the other keeps it.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    MODE_DESEL  = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_OUTOFF = 3'd2,
    MODE_READ   = 3'd3,
    MODE_WRITE  = 3'd4
  } psramMode_e;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wipe;
    logic drvLo;
    logic drvHi;
  } ctrlStrobes_t;

endpackage

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int ACC_LAT   = 3,
  parameter int PAGE_LAT  = 1,
  parameter bit DIRECT_PD = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              ubN,
  input  logic              lbN,
  input  logic              zzN,
  input  logic              pdArm,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [2:0]        modeOut
);

  localparam int PG_BITS = 4;
  localparam int CNT_W   = $clog2(ACC_LAT + 1);

  psramMode_e        modeD, modeQ;
  logic [ADDR_W-1:0] addrQ;
  logic              lbQ, ubQ;
  logic [CNT_W-1:0]  cntQ;
  logic              sleepOk, pageHit, newAcc;

  generate
    if (DIRECT_PD) begin : g_direct
      assign sleepOk = 1'b1;
    end else begin : g_armed
      assign sleepOk = pdArm;
    end
  endgenerate

  // Mode decode, highest priority first
  always_comb begin
    if (!zzN && sleepOk)        modeD = MODE_SLEEP;
    else if (csN)               modeD = MODE_DESEL;
    else if (ubN && lbN)        modeD = MODE_OUTOFF;
    else if (!weN)              modeD = MODE_WRITE;
    else if (!oeN)              modeD = MODE_READ;
    else                        modeD = MODE_OUTOFF;
  end

  assign pageHit = (modeQ == MODE_READ) &&
                   (addr[ADDR_W-1:PG_BITS] == addrQ[ADDR_W-1:PG_BITS]);
  assign newAcc  = (modeD == MODE_READ) && ((modeQ != MODE_READ) || (addr != addrQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_DESEL;
      addrQ <= '0;
      lbQ   <= 1'b0;
      ubQ   <= 1'b0;
      cntQ  <= '0;
    end else begin
      modeQ <= modeD;
      addrQ <= addr;
      lbQ   <= !lbN;
      ubQ   <= !ubN;
      if (newAcc)
        cntQ <= pageHit ? CNT_W'(PAGE_LAT - 1) : CNT_W'(ACC_LAT - 1);
      else if (cntQ != '0)
        cntQ <= cntQ - 1'b1;
    end
  end

  assign rdValid       = (modeQ == MODE_READ) && (cntQ == '0);
  assign rdAddr        = addrQ;
  assign modeOut       = modeQ;
  assign strobes.wrLo  = (modeD == MODE_WRITE) && !lbN;
  assign strobes.wrHi  = (modeD == MODE_WRITE) && !ubN;
  assign strobes.wipe  = (modeD == MODE_SLEEP) && (modeQ != MODE_SLEEP);
  assign strobes.drvLo = rdValid && lbQ;
  assign strobes.drvHi = rdValid && ubQ;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && zzN) |=> (modeOut == 3'd0 && !strobes.drvLo && !strobes.drvHi)); // R2

  AST_LANES_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drvLo || strobes.drvHi) |-> (modeQ == MODE_READ)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < CNT_W'(ACC_LAT)); // R8

  generate
    if (ACC_LAT > 1) begin : g_slowchk
      AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rstN)
        (newAcc && !pageHit) |=> !rdValid); // R8
    end
    if (DIRECT_PD) begin : g_dirchk
      AST_PIN_SLEEPS: assert property (@(posedge clk) disable iff (!rstN)
        !zzN |=> (modeOut == 3'd1)); // R3
    end else begin : g_armchk
      AST_UNARMED_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
        (!zzN && !pdArm) |=> (modeOut != 3'd1)); // R4
    end
  endgenerate

endmodule

// File: rtl/psram_datapath.sv
module psram_datapath
  import psram_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter logic [15:0] POISON = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData,
  output logic              rdPoison
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]      mem [DEPTH];
  logic [DEPTH-1:0] vLo, vHi;
  logic [15:0]      word;
  logic             okLo, okHi;

  always_ff @(posedge clk) begin
    if (strobes.wrLo) mem[wrAddr][7:0]  <= wrData[7:0];
    if (strobes.wrHi) mem[wrAddr][15:8] <= wrData[15:8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vLo <= '0;
      vHi <= '0;
    end else if (strobes.wipe) begin
      vLo <= '0;
      vHi <= '0;
    end else begin
      if (strobes.wrLo) vLo[wrAddr] <= 1'b1;
      if (strobes.wrHi) vHi[wrAddr] <= 1'b1;
    end
  end

  assign word = mem[rdAddr];
  assign okLo = vLo[rdAddr];
  assign okHi = vHi[rdAddr];

  always_comb begin
    rdData = '0;
    if (strobes.drvLo) rdData[7:0]  = okLo ? word[7:0]  : POISON[7:0];
    if (strobes.drvHi) rdData[15:8] = okHi ? word[15:8] : POISON[15:8];
  end

  assign rdPoison = (strobes.drvLo && !okLo) || (strobes.drvHi && !okHi);

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wipe |=> (vLo == '0 && vHi == '0)); // R10

  AST_POISON_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    rdPoison |-> (strobes.drvLo || strobes.drvHi)); // R10

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.drvLo && !strobes.drvHi) |-> (rdData == 16'h0000)); // R6

endmodule

// File: rtl/psram_front.sv
module psram_front
  import psram_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          ACC_LAT   = 3,
  parameter int          PAGE_LAT  = 1,
  parameter bit          DIRECT_PD = 1'b1,
  parameter logic [15:0] POISON    = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              ubN,
  input  logic              lbN,
  input  logic              zzN,
  input  logic              pdArm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              laneOeLo,
  output logic              laneOeHi,
  output logic              rdValid,
  output logic              rdPoison,
  output logic [2:0]        modeOut
);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] rdAddr;

  psram_ctrl #(
    .ADDR_W(ADDR_W), .ACC_LAT(ACC_LAT), .PAGE_LAT(PAGE_LAT), .DIRECT_PD(DIRECT_PD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN), .ubN(ubN),
    .lbN(lbN), .zzN(zzN), .pdArm(pdArm), .addr(addr), .strobes(strobes),
    .rdAddr(rdAddr), .rdValid(rdValid), .modeOut(modeOut)
  );

  psram_datapath #(.ADDR_W(ADDR_W), .POISON(POISON)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(addr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdPoison(rdPoison)
  );

  assign laneOeLo = strobes.drvLo;
  assign laneOeHi = strobes.drvHi;

  initial begin
    assert (ADDR_W > 4 && PAGE_LAT >= 1 && ACC_LAT >= PAGE_LAT)
      else $error("psram_front: bad parameters");
  end

endmodule

// File: tb/psram_front_test.sv
module psram_front_test;

  localparam int AW  = 6;
  localparam int ACC = 3;
  localparam int PG  = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, oeN = 1'b1, weN = 1'b1, ubN = 1'b1, lbN = 1'b1, zzN = 1'b1;
  logic pdArm = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wrData = '0;

  logic [15:0] rdData, rdData2;
  logic laneOeLo, laneOeHi, rdValid, rdPoison;
  logic laneOeLo2, laneOeHi2, rdValid2, rdPoison2;
  logic [2:0] modeOut, modeOut2;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  psram_front #(.ADDR_W(AW), .ACC_LAT(ACC), .PAGE_LAT(PG), .DIRECT_PD(1'b1)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN), .ubN(ubN), .lbN(lbN),
    .zzN(zzN), .pdArm(pdArm), .addr(addr), .wrData(wrData), .rdData(rdData),
    .laneOeLo(laneOeLo), .laneOeHi(laneOeHi), .rdValid(rdValid),
    .rdPoison(rdPoison), .modeOut(modeOut)
  );

  psram_front #(.ADDR_W(AW), .ACC_LAT(ACC), .PAGE_LAT(PG), .DIRECT_PD(1'b0)) uut2 (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN), .ubN(ubN), .lbN(lbN),
    .zzN(zzN), .pdArm(pdArm), .addr(addr), .wrData(wrData), .rdData(rdData2),
    .laneOeLo(laneOeLo2), .laneOeHi(laneOeHi2), .rdValid(rdValid2),
    .rdPoison(rdPoison2), .modeOut(modeOut2)
  );

  function automatic logic [15:0] pat(int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic w, input logic u,
                      input logic l, input logic z, input int a, input logic [15:0] d);
    csN = c; oeN = o; weN = w; ubN = u; lbN = l; zzN = z;
    addr = AW'(a); wrData = d;
  endtask

  // Output-off cycle, then a fresh read held for ACC edges; checks R8 on the way
  task automatic freshRead(input int a, input logic u, input logic l);
    pins(0, 1, 1, 0, 0, 1, a, 16'h0);
    tick();
    pins(0, 0, 1, u, l, 1, a, 16'h0);
    for (int i = 0; i < ACC - 1; i++) tick();
    chk("R8 valid low before latency", {15'b0, rdValid | laneOeLo | laneOeHi}, 16'h0);
    tick();
    chk("R8 valid at latency", {15'b0, rdValid}, 16'h1);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 mode after reset", {13'b0, modeOut}, 16'h0);
    chk("R1 lanes after reset", {14'b0, laneOeHi, laneOeLo}, 16'h0);
    rstN = 1'b1;
    tick();

    // R1 / R10: unwritten word reads poison
    freshRead(5, 0, 0);
    chk("R1 unwritten data", rdData, 16'hDEAD);
    chk("R10 poison flag", {15'b0, rdPoison}, 16'h1);

    // R7: fill array, mix oe high and low during writes
    for (int a = 0; a < (1 << AW); a++) begin
      pins(0, a[0], 0, 0, 0, 1, a, pat(a));
      tick();
      chk("R7 write mode", {13'b0, modeOut}, 16'h4);
      chk("R7 no lane on write", {14'b0, laneOeHi, laneOeLo}, 16'h0);
    end

    // R6 / R8: full-latency readback of every word, R5 between reads
    for (int a = 0; a < (1 << AW); a++) begin
      freshRead(a, 0, 0);
      chk("R6 word data", rdData, pat(a));
      chk("R6 both lanes", {13'b0, modeOut == 3'd3, laneOeHi, laneOeLo}, 16'h7);
      chk("R6 no poison", {15'b0, rdPoison}, 16'h0);
      pins(0, 1, 1, 0, 0, 1, a, 16'h0);
      tick();
      chk("R5 output off", {13'b0, modeOut}, 16'h2);
      chk("R5 lanes off", {14'b0, laneOeHi, laneOeLo}, 16'h0);
    end

    // R9: page burst 16..31
    freshRead(16, 0, 0);
    chk("R9 page start", rdData, pat(16));
    for (int a = 17; a < 32; a++) begin
      pins(0, 0, 1, 0, 0, 1, a, 16'h0);
      for (int i = 0; i < PG; i++) tick();
      chk("R9 page valid", {15'b0, rdValid}, 16'h1);
      chk("R9 page data", rdData, pat(a));
    end
    // R8: leaving the page costs full latency
    pins(0, 0, 1, 0, 0, 1, 32, 16'h0);
    tick();
    chk("R8 page miss not valid", {15'b0, rdValid}, 16'h0);
    tick(); tick();
    chk("R8 page miss valid", rdData, pat(32));

    // R7 / R6: lower-byte-only write, lane-masked reads
    pins(0, 1, 0, 1, 0, 1, 3, 16'hAAAA);
    tick();
    freshRead(3, 1, 0);
    chk("R6 lower lane only", {14'b0, laneOeHi, laneOeLo}, 16'h1);
    chk("R7 lower byte written", rdData, {8'h00, 8'hAA});
    freshRead(3, 0, 1);
    chk("R6 upper lane only", {14'b0, laneOeHi, laneOeLo}, 16'h2);
    chk("R7 upper byte kept", rdData, {pat(3)[15:8], 8'h00});

    // R5: both strobes high with write low stores nothing
    pins(0, 1, 0, 1, 1, 1, 9, 16'h1111);
    tick();
    chk("R5 strobes off mode", {13'b0, modeOut}, 16'h2);
    freshRead(9, 0, 0);
    chk("R5 nothing written", rdData, pat(9));

    // R2: deselect ignores other pins
    pins(1, 0, 0, 0, 0, 1, 9, 16'h2222);
    tick();
    chk("R2 deselected", {11'b0, modeOut, laneOeHi, laneOeLo}, 16'h0);

    // R3 / R4: low-power pin with arm low
    pins(0, 1, 0, 0, 0, 0, 7, 16'h1234);
    tick();
    chk("R3 direct sleeps", {13'b0, modeOut}, 16'h1);
    chk("R3 lanes float", {14'b0, laneOeHi, laneOeLo}, 16'h0);
    chk("R4 armed variant writes", {13'b0, modeOut2}, 16'h4);
    pins(1, 0, 1, 0, 0, 0, 7, 16'h0);
    tick();
    chk("R3 sleep despite deselect", {13'b0, modeOut}, 16'h1);
    freshRead(7, 0, 0);
    chk("R10 direct lost data", rdData, 16'hDEAD);
    chk("R10 direct poison", {15'b0, rdPoison}, 16'h1);
    chk("R4 armed kept write", rdData2, 16'h1234);
    chk("R4 armed no poison", {15'b0, rdPoison2}, 16'h0);

    // R4: arm set, armed variant now sleeps and wipes
    pdArm = 1'b1;
    pins(0, 0, 1, 0, 0, 0, 7, 16'h0);
    tick();
    chk("R4 armed sleeps", {13'b0, modeOut2}, 16'h1);
    pdArm = 1'b0;
    freshRead(7, 0, 0);
    chk("R10 armed lost data", rdData2, 16'hDEAD);
    chk("R10 armed poison", {15'b0, rdPoison2}, 16'h1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule